// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

A purely combinational 32-bit shift unit for a processor datapath. One operand passes through logical left shift, logical right shift, arithmetic right shift, right rotation, or a one-bit rotation through the carry flag. The unit produces the shifted word and a carry bit that the surrounding ALU may latch into its status flags. The status flags themselves are kept outside this block.

The shift amount comes in one of two forms. In immediate form, only the low five bits of `shiftAmount` count. An encoded zero has a special meaning that depends on the kind of shift. In register form, all eight bits count, so amounts from 0 to 255 are possible. A register amount of zero leaves the operand and the carry untouched.

Internally, a decode stage turns kind, form and amount into a small set of strobes and an effective count from 1 to 32. A datapath stage applies those strobes through a logarithmic right-shift network.

Top module: `shift_rotate_unit`

## Requirements
- R1: Kind code 1 is logical right shift by n (1..32). Upper bits fill with zeros and carryOut is operand bit n-1. For example, 0xF0F0F0F0 by 5 gives 0x07878787.
- R2: Kind code 0 is logical left shift by n (1..32). Lower bits fill with zeros and carryOut is operand bit 32-n. For example, 0xF0F0F0F0 by 5 gives 0x1E1E1E00.
- R3: Kind code 2 is arithmetic right shift by n (1..32). Upper bits fill with operand bit 31 and carryOut is operand bit n-1. For example, 0xF0F0F0F0 by 5 gives 0xFF878787.
- R4: Kind code 3 is right rotation. Bits leaving the low end re-enter at the high end, and carryOut equals result bit 31. For example, 0xF0F0F0F0 by 5 gives 0x87878787.
- R5: With amountFromReg=0, only shiftAmount[4:0] is used. Bits 7:5 have no effect on either output.
- R6: With amountFromReg=0 and an amount field of 0, the result depends on the kind:
  - left shift returns the operand unchanged, with carryOut=carryIn;
  - logical right shift returns 0 with carryOut=operand[31];
  - arithmetic right shift returns 32 copies of operand[31], with carryOut=operand[31].
- R7: With amountFromReg=0, kind 3 and an amount field of 0, the unit performs a rotate-with-extend. The result is {carryIn, operand[31:1]} and carryOut=operand[0].
- R8: With amountFromReg=1 and shiftAmount=0, every kind returns the operand unchanged, with carryOut=carryIn.
- R9: With amountFromReg=1 and shiftAmount=32, left shift gives 0 with carryOut=operand[0], and logical right shift gives 0 with carryOut=operand[31].
- R10: With amountFromReg=1 and shiftAmount above 32, both logical shifts give 0 with carryOut=0. Arithmetic right shift by any amount of 32 or more gives 32 copies of operand[31], with carryOut=operand[31].
- R11: With amountFromReg=1, rotation uses the amount modulo 32. A nonzero amount that is a multiple of 32 returns the operand, with carryOut=operand[31].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operandIn | input | 32 | Word to be shifted |
| shiftKind | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amountFromReg | input | 1 | 1: 8-bit register amount, 0: 5-bit immediate amount |
| shiftAmount | input | 8 | Shift amount |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 32 | Shifted word |
| carryOut | output | 1 | Carry produced by the shift |

## Verification
Both outputs depend only on the current inputs through combinational logic, so each result is due in the same cycle as its stimulus, with no register anywhere on the path. The bench applies each input set just after a falling clock edge and waits one nanosecond before it compares against its own arithmetic model. Every comparison therefore completes before the next rising edge and before any new stimulus. The sweep covers every kind, both amount forms and every 8-bit amount, under both carry-in values and a spread of operands.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;
  localparam int DATA_W = 32;
  localparam int AMT_W  = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = IDX_W + 1;

  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2,
    KIND_ROR = 2'd3
  } shiftKind_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic             passThru;  // operand and carry through unchanged
    logic             doRrx;     // one-bit rotate through carry
    logic             clearAll;  // zero result, zero carry
    logic             leftDir;   // left shift via bit reversal
    logic             fillSign;  // upper fill from sign bit
    logic             rotate;    // upper fill from operand itself
    logic [CNT_W-1:0] count;     // effective amount 1..DATA_W
  } shiftCtl_t;
endpackage

// File: rtl/shift_rotate_ctrl.sv
module shift_rotate_ctrl
  import shift_rotate_pkg::*;
(
  input  logic [1:0]       shiftKind,
  input  logic             amountFromReg,
  input  logic [AMT_W-1:0] shiftAmount,
  output shiftCtl_t        ctl
);
  shiftKind_e       kindE;
  logic [IDX_W-1:0] lowAmt;

  assign kindE  = shiftKind_e'(shiftKind);
  assign lowAmt = shiftAmount[IDX_W-1:0];

  always_comb begin
    ctl          = '0;
    ctl.count    = CNT_W'(1);
    ctl.leftDir  = (kindE == KIND_LSL);
    ctl.fillSign = (kindE == KIND_ASR);
    ctl.rotate   = (kindE == KIND_ROR);
    if (!amountFromReg) begin
      if (lowAmt == '0) begin
        case (kindE)
          KIND_LSL: ctl.passThru = 1'b1;
          KIND_ROR: ctl.doRrx    = 1'b1;
          default:  ctl.count    = CNT_W'(DATA_W);
        endcase
      end else begin
        ctl.count = {1'b0, lowAmt};
      end
    end else if (shiftAmount == '0) begin
      ctl.passThru = 1'b1;
    end else begin
      case (kindE)
        KIND_LSL, KIND_LSR: begin
          if (shiftAmount > AMT_W'(DATA_W)) ctl.clearAll = 1'b1;
          else                              ctl.count    = CNT_W'(shiftAmount);
        end
        KIND_ASR: begin
          if (shiftAmount >= AMT_W'(DATA_W)) ctl.count = CNT_W'(DATA_W);
          else                               ctl.count = CNT_W'(shiftAmount);
        end
        default: begin
          if (lowAmt == '0) ctl.count = CNT_W'(DATA_W);
          else              ctl.count = {1'b0, lowAmt};
        end
      endcase
    end
  end
endmodule

// File: rtl/shift_rotate_path.sv
module shift_rotate_path
  import shift_rotate_pkg::*;
(
  input  logic [DATA_W-1:0] operandIn,
  input  logic              carryIn,
  input  shiftCtl_t         ctl,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut
);
  logic [DATA_W-1:0] srcVec;
  logic [DATA_W-1:0] fillVec;
  logic [DATA_W-1:0] rawRes;
  logic [DATA_W-1:0] dirRes;
  logic [IDX_W-1:0]  stepAmt;
  logic [DATA_W:0]   picked;
  logic [2*DATA_W-1:0] work;

  // reversal makes a left shift out of a right shift
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign srcVec[i] = ctl.leftDir ? operandIn[DATA_W-1-i] : operandIn[i];
    assign dirRes[i] = ctl.leftDir ? rawRes[DATA_W-1-i]    : rawRes[i];
  end

  assign fillVec = ctl.rotate   ? srcVec :
                   ctl.fillSign ? {DATA_W{operandIn[DATA_W-1]}} : '0;

  // shift by count-1, the last step of one is taken by the bit pick below
  assign stepAmt = IDX_W'(ctl.count - CNT_W'(1));

  always_comb begin
    work = {fillVec, srcVec};
    for (int k = 0; k < IDX_W; k++) begin
      if (stepAmt[k]) work = work >> (1 << k);
    end
    picked = work[DATA_W:0];
  end

  assign rawRes = picked[DATA_W:1];

  always_comb begin
    if (ctl.passThru) begin
      resultOut = operandIn;
      carryOut  = carryIn;
    end else if (ctl.doRrx) begin
      resultOut = {carryIn, operandIn[DATA_W-1:1]};
      carryOut  = operandIn[0];
    end else if (ctl.clearAll) begin
      resultOut = '0;
      carryOut  = 1'b0;
    end else begin
      resultOut = dirRes;
      carryOut  = picked[0];
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
(
  input  logic [31:0] operandIn,
  input  logic [1:0]  shiftKind,
  input  logic        amountFromReg,
  input  logic [7:0]  shiftAmount,
  input  logic        carryIn,
  output logic [31:0] resultOut,
  output logic        carryOut
);
  shiftCtl_t ctl;

  shift_rotate_ctrl u_ctrl (
    .shiftKind     (shiftKind),
    .amountFromReg (amountFromReg),
    .shiftAmount   (shiftAmount),
    .ctl           (ctl)
  );

  shift_rotate_path u_path (
    .operandIn (operandIn),
    .carryIn   (carryIn),
    .ctl       (ctl),
    .resultOut (resultOut),
    .carryOut  (carryOut)
  );
endmodule

// File: rtl/shift_rotate_checker.sv
module shift_rotate_checker (
  input logic [31:0] operandIn,
  input logic [1:0]  shiftKind,
  input logic        amountFromReg,
  input logic [7:0]  shiftAmount,
  input logic        carryIn,
  input logic [31:0] resultOut,
  input logic        carryOut
);
  always_comb begin
    if (!$isunknown({operandIn, shiftKind, amountFromReg, shiftAmount, carryIn,
                     resultOut, carryOut})) begin
      if (amountFromReg && shiftAmount == 8'd0) begin
        AST_REG_ZERO_PASS: assert (resultOut == operandIn && carryOut == carryIn); // R8
      end
      if (amountFromReg && shiftAmount > 8'd32 && !shiftKind[1]) begin
        AST_LOGIC_CLEAR: assert (resultOut == 32'd0 && !carryOut); // R10
      end
      if (shiftKind == 2'd2) begin
        AST_ASR_SIGN_KEPT: assert (resultOut[31] == operandIn[31]); // R3
      end
      if (shiftKind == 2'd3 && !(amountFromReg == 1'b0 && shiftAmount[4:0] == 5'd0)
          && !(amountFromReg && shiftAmount == 8'd0)) begin
        AST_ROR_CARRY_TOP: assert (carryOut == resultOut[31]); // R4
        AST_ROR_POPCOUNT: assert ($countones(resultOut) == $countones(operandIn)); // R4
      end
      if (!amountFromReg && shiftKind == 2'd0 && shiftAmount[4:0] == 5'd0) begin
        AST_IMM_LSL_PASS: assert (resultOut == operandIn && carryOut == carryIn); // R6
      end
      if (!amountFromReg && shiftKind == 2'd3 && shiftAmount[4:0] == 5'd0) begin
        AST_RRX_CARRY: assert (carryOut == operandIn[0] && resultOut[31] == carryIn); // R7
      end
    end
  end
endmodule

bind shift_rotate_unit shift_rotate_checker u_chk (.*);

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;
  logic        clk = 1'b0;
  logic [31:0] operandIn = '0;
  logic [1:0]  shiftKind = '0;
  logic        amountFromReg = 1'b1;
  logic [7:0]  shiftAmount = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic        carryOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shift_rotate_unit uut (
    .operandIn     (operandIn),
    .shiftKind     (shiftKind),
    .amountFromReg (amountFromReg),
    .shiftAmount   (shiftAmount),
    .carryIn       (carryIn),
    .resultOut     (resultOut),
    .carryOut      (carryOut)
  );

  function automatic void refModel(input logic [31:0] op, input logic [1:0] kind,
                                   input logic fromReg, input logic [7:0] amt,
                                   input logic cin, output logic [31:0] res,
                                   output logic cout);
    int n;
    logic [63:0] tmp;
    if (!fromReg) n = int'(amt[4:0]);
    else          n = int'(amt);
    res = op; cout = cin;
    if (!fromReg && n == 0) begin
      case (kind)
        2'd0: begin res = op; cout = cin; end
        2'd1: begin res = 32'd0; cout = op[31]; end
        2'd2: begin res = {32{op[31]}}; cout = op[31]; end
        default: begin res = {cin, op[31:1]}; cout = op[0]; end
      endcase
    end else if (n != 0) begin
      case (kind)
        2'd0: if (n > 32) begin res = 0; cout = 0; end
              else begin tmp = {32'd0, op} << n; res = tmp[31:0]; cout = tmp[32]; end
        2'd1: if (n > 32) begin res = 0; cout = 0; end
              else begin tmp = {op, 32'd0} >> n; res = tmp[63:32]; cout = tmp[31]; end
        2'd2: begin
          tmp = $signed({op, 32'd0}) >>> ((n > 32) ? 32 : n);
          res = tmp[63:32]; cout = tmp[31];
        end
        default: begin
          if (n % 32 == 0) begin res = op; cout = op[31]; end
          else begin res = (op >> (n % 32)) | (op << (32 - n % 32)); cout = res[31]; end
        end
      endcase
    end
  endfunction

  function automatic string reqTag(input logic [1:0] kind, input logic fromReg,
                                   input logic [7:0] amt);
    if (fromReg) begin
      if (amt == 0) return "R8";
      if (kind == 2'd3) return "R11";
      if (amt > 32 || (amt == 32 && kind == 2'd2)) return "R10";
      if (amt == 32) return "R9";
    end else begin
      if (amt[7:5] != 0) return "R5";
      if (amt[4:0] == 0) return (kind == 2'd3) ? "R7" : "R6";
    end
    case (kind)
      2'd0: return "R2";
      2'd1: return "R1";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic applyCheck(input logic [31:0] op, input logic [1:0] kind,
                            input logic fromReg, input logic [7:0] amt, input logic cin,
                            input string tag);
    logic [31:0] expRes;
    logic expC;
    @(negedge clk);
    operandIn = op; shiftKind = kind; amountFromReg = fromReg;
    shiftAmount = amt; carryIn = cin;
    #1;
    refModel(op, kind, fromReg, amt, cin, expRes, expC);
    testsRun++;
    if (resultOut !== expRes || carryOut !== expC) begin
      testsFailed++;
      $display("FAIL %s op=%h kind=%0d reg=%0d amt=%0d cin=%0d: got %h/%0b expected %h/%0b",
               tag, op, kind, fromReg, amt, cin, resultOut, carryOut, expRes, expC);
    end
  endtask

  task automatic fixedCheck(input logic [1:0] kind, input logic [31:0] expRes,
                            input string tag);
    @(negedge clk);
    operandIn = 32'hF0F0F0F0; shiftKind = kind; amountFromReg = 1'b0;
    shiftAmount = 8'd5; carryIn = 1'b0;
    #1;
    testsRun++;
    if (resultOut !== expRes) begin
      testsFailed++;
      $display("FAIL %s reference vector: got %h expected %h", tag, resultOut, expRes);
    end
  endtask

  initial begin
    logic [31:0] ops [8];
    logic [31:0] lcg;
    ops[0] = 32'hF0F0F0F0; ops[1] = 32'h80000001; ops[2] = 32'h12345678;
    ops[3] = 32'hFFFFFFFF; ops[4] = 32'h00000000; ops[5] = 32'h7FFFFFFE;
    ops[6] = 32'hA5A5A5A5;
    lcg = 32'h1F2E3D4C;
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    ops[7] = lcg;

    // initial state with all-zero inputs, register amount 0: R8
    applyCheck(32'd0, 2'd0, 1'b1, 8'd0, 1'b0, "R8");

    fixedCheck(2'd1, 32'h07878787, "R1");
    fixedCheck(2'd0, 32'h1E1E1E00, "R2");
    fixedCheck(2'd2, 32'hFF878787, "R3");
    fixedCheck(2'd3, 32'h87878787, "R4");

    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 4; k++) begin
        for (int m = 0; m < 2; m++) begin
          for (int a = 0; a < 256; a++) begin
            for (int c = 0; c < 2; c++) begin
              applyCheck(ops[o], 2'(k), 1'(m), 8'(a), 1'(c),
                         reqTag(2'(k), 1'(m), 8'(a)));
            end
          end
        end
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule